// File: doc/BRIEF.md
# Signal Data Capture Tap Unit

This block watches the datapath of a sequenced audio processor and freezes selected intermediate values for inspection. The processor runs through a fixed list of steps every frame and announces each step with an index and the value on its datapath. The unit has eight capture channels. Each channel holds a tap step index, and when the announced step matches that index the channel stores the datapath value.

A host programs the tap indices and reads captures through a small synchronous register port. Six channels are readable by the host. The last two channels are not host-readable. At every frame boundary they are copied to a left/right sample pair for a stereo serializer, so any internal signal can be sent to an external converter or analyser.

A new tap index is held as pending and becomes active at the next frame boundary. A frame therefore never captures from two different steps. A host read returns the value held before any capture in the same clock cycle.

Top module: `sig_tap_unit`

## Requirements
- R1: After synchronous reset, all tap indices, captures, `mon_left`, `mon_right` and `host_rd_data` are zero, and `mon_strobe` is low.
- R2: When `step_valid` is high and `step_idx` equals a channel's active tap index, that channel's capture takes `step_data` at the clock edge. Reads and the monitor see the new value from the next cycle.
- R3: A channel's capture is unchanged in any cycle where `step_valid` is low, or where `step_idx` differs from its active tap, whatever `step_data` holds.
- R4: A host write to address k (0 to 7) stores bits [9:0] of `host_wr_data` as channel k's pending tap. The active tap takes the pending value only at a `frame_sync` cycle. A step in that same `frame_sync` cycle is still matched against the old tap.
- R5: A read (`host_rd_en`) of address k (0 to 7) returns channel k's pending tap, zero-extended, on `host_rd_data` one cycle later.
- R6: A read of address 8+k (k = 0 to 5) returns channel k's capture one cycle later. If a capture into that channel occurs in the same cycle as the read, the read returns the value held before that capture.
- R7: Reads of addresses 14 and 15 return zero. Host writes to addresses 8 to 15 change no tap and no capture.
- R8: On a `frame_sync` cycle, `mon_left` takes channel 6's capture and `mon_right` takes channel 7's capture, both as they were before any capture in that cycle. `mon_strobe` is high in the following cycle only. In all other cycles both monitor outputs hold their value.
- R9: Channels that share the same active tap all capture the same `step_data` value on the matching step.
- R10: `host_rd_data` keeps its value in every cycle that follows a cycle without `host_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | Sequencer step qualifier |
| step_idx | input | 10 | Index of the current processing step |
| step_data | input | 28 | Datapath value at this step |
| frame_sync | input | 1 | Frame boundary pulse |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 4 | Host register address |
| host_wr_data | input | 28 | Host write data |
| host_rd_data | output | 28 | Registered host read data |
| mon_left | output | 28 | Left monitor sample (channel 6) |
| mon_right | output | 28 | Right monitor sample (channel 7) |
| mon_strobe | output | 1 | One-cycle pulse marking a new monitor pair |

## Verification
Each result of this block is due exactly one register stage after its cause:
- a matching step appears in the capture one edge later;
- `host_rd_data` answers a read one edge later;
- the monitor pair and `mon_strobe` follow `frame_sync` by one edge.

The bench changes inputs on the falling edge. It samples outputs on the next falling edge, after the single rising edge that carries the effect. The timing-sensitive cases are applied in a single cycle each: a read coinciding with a capture, and a step coinciding with a frame boundary. The bench then checks which value came out. Tap sets are swept arithmetically over whole frames, and each expected capture is computed from the tap index and the frame number.

// File: rtl/sig_tap_pkg.sv
package sig_tap_pkg;

    parameter int unsigned TAP_DATA_W     = 28;
    parameter int unsigned TAP_CHANS      = 8;
    parameter int unsigned TAP_HOST_CHANS = 6;
    parameter int unsigned TAP_STEP_W     = 10;

    // Kind of register selected by a host address
    typedef enum logic [1:0] {
        REG_TAP  = 2'd0,
        REG_CAP  = 2'd1,
        REG_NONE = 2'd2
    } reg_kind_e;

    function automatic reg_kind_e decode_kind(input int unsigned addr,
                                              input int unsigned nch,
                                              input int unsigned nhost);
        if (addr < nch)
            return REG_TAP;
        else if (addr < nch + nhost)
            return REG_CAP;
        else
            return REG_NONE;
    endfunction

endpackage

// File: rtl/sig_tap_chan.sv
module sig_tap_chan #(
    parameter int unsigned DATA_W = 28,
    parameter int unsigned STEP_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tap_we,
    input  logic [STEP_W-1:0] tap_wdata,
    input  logic              frame_sync,
    input  logic              step_valid,
    input  logic [STEP_W-1:0] step_idx,
    input  logic [DATA_W-1:0] step_data,
    output logic [STEP_W-1:0] tap_pend,
    output logic [DATA_W-1:0] cap_q
);

    logic [STEP_W-1:0] tap_act;
    logic              hit;

    // Matched against the active index, so a boundary cycle still uses the old one
    assign hit = step_valid && (step_idx == tap_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_pend <= '0;
            tap_act  <= '0;
            cap_q    <= '0;
        end else begin
            if (tap_we)
                tap_pend <= tap_wdata;
            if (frame_sync)
                tap_act <= tap_pend;
            if (hit)
                cap_q <= step_data;
        end
    end

endmodule

// File: rtl/sig_tap_host.sv
module sig_tap_host
    import sig_tap_pkg::*;
#(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned NUM_HOST = 6,
    parameter int unsigned DATA_W   = 28,
    parameter int unsigned STEP_W   = 10,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NUM_CH-1:0][STEP_W-1:0] tap_pend_bus,
    input  logic [NUM_CH-1:0][DATA_W-1:0] cap_bus,
    output logic [NUM_CH-1:0]             tap_we,
    output logic [STEP_W-1:0]             tap_wdata,
    output logic [DATA_W-1:0]             rd_data
);

    reg_kind_e         kind;
    logic [DATA_W-1:0] rd_next;

    assign kind      = decode_kind(int'(addr), NUM_CH, NUM_HOST);
    assign tap_wdata = wdata[STEP_W-1:0];

    always_comb begin
        for (int i = 0; i < NUM_CH; i++)
            tap_we[i] = wr_en && (kind == REG_TAP) && (addr == ADDR_W'(i));
    end

    always_comb begin
        rd_next = '0;
        if (kind == REG_TAP) begin
            for (int i = 0; i < NUM_CH; i++)
                if (addr == ADDR_W'(i))
                    rd_next = DATA_W'(tap_pend_bus[i]);
        end else if (kind == REG_CAP) begin
            for (int k = 0; k < NUM_HOST; k++)
                if (addr == ADDR_W'(NUM_CH + k))
                    rd_next = cap_bus[k];
        end
    end

    // Sampling the capture registers before this edge's update keeps reads whole
    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_next;
    end

endmodule

// File: rtl/sig_tap_mon.sv
module sig_tap_mon #(
    parameter int unsigned DATA_W = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync,
    input  logic [DATA_W-1:0] left_in,
    input  logic [DATA_W-1:0] right_in,
    output logic [DATA_W-1:0] mon_left,
    output logic [DATA_W-1:0] mon_right,
    output logic              mon_strobe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_left   <= '0;
            mon_right  <= '0;
            mon_strobe <= 1'b0;
        end else begin
            mon_strobe <= frame_sync;
            if (frame_sync) begin
                mon_left  <= left_in;
                mon_right <= right_in;
            end
        end
    end

endmodule

// File: rtl/sig_tap_unit.sv
module sig_tap_unit
    import sig_tap_pkg::*;
#(
    parameter int unsigned DATA_W   = TAP_DATA_W,
    parameter int unsigned NUM_CH   = TAP_CHANS,
    parameter int unsigned NUM_HOST = TAP_HOST_CHANS,
    parameter int unsigned STEP_W   = TAP_STEP_W,
    localparam int unsigned ADDR_W  = $clog2(2 * NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_valid,
    input  logic [STEP_W-1:0] step_idx,
    input  logic [DATA_W-1:0] step_data,
    input  logic              frame_sync,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wr_data,
    output logic [DATA_W-1:0] host_rd_data,
    output logic [DATA_W-1:0] mon_left,
    output logic [DATA_W-1:0] mon_right,
    output logic              mon_strobe
);

    logic [NUM_CH-1:0][STEP_W-1:0] tap_pend_bus;
    logic [NUM_CH-1:0][DATA_W-1:0] cap_bus;
    logic [NUM_CH-1:0]             tap_we;
    logic [STEP_W-1:0]             tap_wdata;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        sig_tap_chan #(
            .DATA_W (DATA_W),
            .STEP_W (STEP_W)
        ) i_chan (
            .clk        (clk),
            .rst        (rst),
            .tap_we     (tap_we[g]),
            .tap_wdata  (tap_wdata),
            .frame_sync (frame_sync),
            .step_valid (step_valid),
            .step_idx   (step_idx),
            .step_data  (step_data),
            .tap_pend   (tap_pend_bus[g]),
            .cap_q      (cap_bus[g])
        );
    end

    sig_tap_host #(
        .NUM_CH   (NUM_CH),
        .NUM_HOST (NUM_HOST),
        .DATA_W   (DATA_W),
        .STEP_W   (STEP_W),
        .ADDR_W   (ADDR_W)
    ) i_host (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (host_wr_en),
        .rd_en        (host_rd_en),
        .addr         (host_addr),
        .wdata        (host_wr_data),
        .tap_pend_bus (tap_pend_bus),
        .cap_bus      (cap_bus),
        .tap_we       (tap_we),
        .tap_wdata    (tap_wdata),
        .rd_data      (host_rd_data)
    );

    // The two highest channels feed the stereo monitor
    sig_tap_mon #(
        .DATA_W (DATA_W)
    ) i_mon (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .left_in    (cap_bus[NUM_CH-2]),
        .right_in   (cap_bus[NUM_CH-1]),
        .mon_left   (mon_left),
        .mon_right  (mon_right),
        .mon_strobe (mon_strobe)
    );

endmodule

// File: rtl/sig_tap_chk.sv
module sig_tap_chk #(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned NUM_HOST = 6,
    parameter int unsigned DATA_W   = 28,
    parameter int unsigned STEP_W   = 10,
    parameter int unsigned ADDR_W   = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          step_valid,
    input logic                          frame_sync,
    input logic                          host_rd_en,
    input logic [ADDR_W-1:0]             host_addr,
    input logic [DATA_W-1:0]             host_rd_data,
    input logic [DATA_W-1:0]             mon_left,
    input logic [DATA_W-1:0]             mon_right,
    input logic                          mon_strobe,
    input logic [NUM_CH-1:0][STEP_W-1:0] tap_pend_bus,
    input logic [NUM_CH-1:0][DATA_W-1:0] cap_bus
);

    // R8
    strobe_after_sync_chk: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> mon_strobe);

    // R8
    strobe_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
        mon_strobe |-> $past(frame_sync));

    // R8
    mon_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |=> ($stable(mon_left) && $stable(mon_right)));

    // R3
    cap_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !step_valid |=> $stable(cap_bus));

    // R5
    tap_read_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && host_addr == ADDR_W'(0))
        |=> host_rd_data == DATA_W'($past(tap_pend_bus[0])));

    // R6
    cap_read_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && host_addr == ADDR_W'(NUM_CH))
        |=> host_rd_data == $past(cap_bus[0]));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd_en |=> $stable(host_rd_data));

    if (NUM_CH + NUM_HOST < (1 << ADDR_W)) begin : g_hole
        // R7
        hole_read_chk: assert property (@(posedge clk) disable iff (rst)
            (host_rd_en && host_addr == '1) |=> host_rd_data == '0);
    end

endmodule

bind sig_tap_unit sig_tap_chk #(
    .NUM_CH   (NUM_CH),
    .NUM_HOST (NUM_HOST),
    .DATA_W   (DATA_W),
    .STEP_W   (STEP_W),
    .ADDR_W   (ADDR_W)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .step_valid   (step_valid),
    .frame_sync   (frame_sync),
    .host_rd_en   (host_rd_en),
    .host_addr    (host_addr),
    .host_rd_data (host_rd_data),
    .mon_left     (mon_left),
    .mon_right    (mon_right),
    .mon_strobe   (mon_strobe),
    .tap_pend_bus (tap_pend_bus),
    .cap_bus      (cap_bus)
);

// File: tb/test_sig_tap_unit.sv
`timescale 1ns/1ps
module test_sig_tap_unit;

    localparam int DW = 28;
    localparam int SW = 10;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          step_valid = 1'b0;
    logic [SW-1:0] step_idx = '0;
    logic [DW-1:0] step_data = '0;
    logic          frame_sync = 1'b0;
    logic          host_wr_en = 1'b0;
    logic          host_rd_en = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wr_data = '0;
    logic [DW-1:0] host_rd_data;
    logic [DW-1:0] mon_left;
    logic [DW-1:0] mon_right;
    logic          mon_strobe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [DW-1:0] exp_cap [8];
    logic [SW-1:0] taps    [8];

    always #5 clk = ~clk;

    sig_tap_unit i_sig_tap_unit (
        .clk(clk), .rst(rst), .step_valid(step_valid), .step_idx(step_idx),
        .step_data(step_data), .frame_sync(frame_sync), .host_wr_en(host_wr_en),
        .host_rd_en(host_rd_en), .host_addr(host_addr), .host_wr_data(host_wr_data),
        .host_rd_data(host_rd_data), .mon_left(mon_left), .mon_right(mon_right),
        .mon_strobe(mon_strobe)
    );

    function automatic logic [DW-1:0] dval(input int idx, input int fno);
        logic [SW-1:0] i10 = SW'(idx);
        return {8'(fno), i10, i10 ^ 10'h2A5};
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: inputs set after a falling edge, outputs sampled at the next falling edge
    task automatic cyc(input bit fs, input bit sv, input int idx, input logic [DW-1:0] d,
                       input bit rd, input bit wr, input int a, input logic [DW-1:0] wd);
        frame_sync = fs; step_valid = sv; step_idx = SW'(idx); step_data = d;
        host_rd_en = rd; host_wr_en = wr; host_addr = AW'(a); host_wr_data = wd;
        @(posedge clk);
        @(negedge clk);
        frame_sync = 0; step_valid = 0; host_rd_en = 0; host_wr_en = 0;
    endtask

    task automatic hread(input int a, output logic [DW-1:0] v);
        cyc(0, 0, 0, '0, 1, 0, a, '0);
        v = host_rd_data;
    endtask

    task automatic hwrite(input int a, input logic [DW-1:0] wd);
        cyc(0, 0, 0, '0, 0, 1, a, wd);
    endtask

    task automatic frame_pulse(input bit sv, input int idx, input logic [DW-1:0] d);
        cyc(1, sv, idx, d, 0, 0, 0, '0);
    endtask

    task automatic run_steps(input int lo, input int hi, input int fno);
        for (int s = lo; s <= hi; s++) begin
            cyc(0, 1, s, dval(s, fno), 0, 0, 0, '0);
            for (int k = 0; k < 8; k++)
                if (int'(taps[k]) == s) exp_cap[k] = dval(s, fno);
        end
    endtask

    task automatic check_caps(input string req);
        logic [DW-1:0] v;
        for (int k = 0; k < 6; k++) begin
            hread(8 + k, v);
            check(req, v, exp_cap[k]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] old6, old7;

        for (int k = 0; k < 8; k++) begin exp_cap[k] = '0; taps[k] = '0; end
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: everything zero after reset
        check("R1 mon_left", mon_left, '0);
        check("R1 mon_right", mon_right, '0);
        check("R1 strobe", DW'(mon_strobe), '0);
        check("R1 rd_data", host_rd_data, '0);
        for (int a = 0; a < 16; a++) begin
            hread(a, v);
            check("R1 reg", v, '0);
        end

        // Sweep of tap sets, one frame each; trial 4 puts every channel on step 9 (R9)
        for (int t = 0; t < 5; t++) begin
            for (int k = 0; k < 8; k++) begin
                taps[k] = (t == 4) ? SW'(9) : SW'((k * 5 + t * 7 + 1) % 32);
                hwrite(k, {18'h3FFFF, taps[k]});
            end
            for (int k = 0; k < 8; k++) begin
                hread(k, v);
                check("R5 tap readback", v, DW'(taps[k]));
            end
            frame_pulse(0, 0, '0);
            check("R8 strobe", DW'(mon_strobe), 1);
            check("R8 left", mon_left, exp_cap[6]);
            check("R8 right", mon_right, exp_cap[7]);
            old6 = exp_cap[6];
            old7 = exp_cap[7];
            cyc(0, 0, 0, '0, 0, 0, 0, '0);
            check("R8 strobe low", DW'(mon_strobe), 0);
            run_steps(0, 31, t + 1);
            check_caps(t == 4 ? "R9 shared tap" : "R2 capture");
            check("R8 hold left", mon_left, old6);
            check("R8 hold right", mon_right, old7);
        end

        // R4: new tap stays pending until the boundary; boundary cycle uses the old tap
        hwrite(1, DW'(20));
        cyc(0, 1, 20, 28'hA11_1111, 0, 0, 0, '0);
        hread(9, v);
        check("R4 pending ignored", v, exp_cap[1]);
        old6 = exp_cap[6];
        frame_pulse(1, 9, 28'hB22_2222);
        check("R8 pre-capture left", mon_left, old6);
        for (int k = 0; k < 8; k++) exp_cap[k] = 28'hB22_2222;
        taps[1] = SW'(20);
        check_caps("R4 old tap at boundary");
        cyc(0, 1, 20, 28'hC33_3333, 0, 0, 0, '0);
        exp_cap[1] = 28'hC33_3333;
        check_caps("R4 new tap active");

        // R3: qualifier low, or non-matching steps
        cyc(0, 0, 9, 28'hDEAD_BEE, 0, 0, 0, '0);
        cyc(0, 0, 20, 28'hDEAD_BEE, 0, 0, 0, '0);
        run_steps(32, 63, 7);
        check_caps("R3 no capture");

        // R6: read coincides with a capture into the same channel
        cyc(0, 1, 20, 28'h5A5_A5A5, 1, 0, 9, '0);
        check("R6 atomic old", host_rd_data, 28'hC33_3333);
        hread(9, v);
        check("R6 atomic new", v, 28'h5A5_A5A5);
        exp_cap[1] = 28'h5A5_A5A5;

        // R7: writes to capture space ignored, holes read zero
        hwrite(9, 28'h0FF_FFFF);
        hwrite(15, 28'h0FF_FFFF);
        hread(9, v);
        check("R7 cap write ignored", v, 28'h5A5_A5A5);
        hread(1, v);
        check("R7 tap unchanged", v, DW'(20));
        hread(14, v);
        check("R7 hole 14", v, '0);
        hread(15, v);
        check("R7 hole 15", v, '0);

        // R10: read data holds while idle
        hread(1, v);
        repeat (3) cyc(0, 1, 20, 28'h123_4567, 0, 0, 0, '0);
        check("R10 rd hold", host_rd_data, DW'(20));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule